// File: doc/BRIEF.md
# Byte FIFO with Watermark Flags

A byte-wide data queue that sits between a 32-bit register bus and a serial byte engine for a two-wire bus controller. One data address on the register bus moves one, two or four bytes per access into or out of the queue. The engine side moves one byte per handshake. The transfer direction is set by `rx_mode`. When it is low (transmit), software writes bytes and the engine drains them. When it is high (receive), the engine fills the queue and software reads it.

Two status words are produced for a neighbouring register file. The main status word carries the fill count and a service-request bit. The extended status word carries the fixed capacity and two watermark flags. The flags are compared against thresholds taken from a watermark configuration word. The service request follows the low-water flag while transmitting and the high-water flag while receiving. An access that does not fit is refused whole and sets a sticky error. A flush strobe empties everything. `DEPTH` must be a power of two between 4 and 128.

Top module: `i2c_byte_fifo`

## Requirements
- R1: While and after reset the fill count, both watermark flags, the service request and the error are 0. `ext_word[31:24]` always reads `DEPTH`, and all other bits of both status words are 0.
- R2: In transmit mode, a bus write with size code 0, 1 or 2 appends 1, 2 or 4 bytes. The first byte is taken from `bus_wdata[31:24]`, the next from `[23:16]`, and so on. Each `eng_pop` removes one byte, and `eng_rbyte` shows the oldest byte before the pop.
- R3: In receive mode, each `eng_push` appends `eng_wbyte`. A bus read of n bytes returns the oldest byte in `bus_rdata[31:24]` and the following bytes in the lanes below it, with unused lanes zero. It then removes those n bytes.
- R4: `stat_word[7:0]` equals the number of bytes held. The count is updated on the clock edge that accepts an access.
- R5: Any of the following access attempts is refused with no effect on contents or count, and sets the sticky error `fifo_err`: a push larger than the free space, a pop larger than the bytes held, or a bus access with size code 3.
- R6: Accesses from the side that does not own a direction are ignored, and `bus_rdata` is 0 whenever no receive-mode bus read is presented. In transmit mode these are bus reads and engine pushes. In receive mode they are bus writes and engine pops.
- R7: After every edge that accepts an access, two flags are recomputed from the new count. `ext_word[9]` is set when count >= `wmark_cfg[15:12]`. `ext_word[8]` is set when count <= `wmark_cfg[7:4]`. On other edges both flags hold their value.
- R8: `stat_word[25]` equals the low-water flag in transmit mode and the high-water flag in receive mode.
- R9: `flush` empties the queue and clears both flags and the error on the next edge. It takes priority over any access in the same cycle.
- R10: In transmit mode, a bus write and an engine pop in the same cycle are both judged against the count at the start of the cycle, and both take effect.
- R11: Byte order is preserved when the storage pointers wrap, including multi-byte accesses that straddle the wrap point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty strobe; clears flags and error |
| rx_mode | input | 1 | 1: engine fills, bus drains; 0: bus fills, engine drains |
| wmark_cfg | input | 16 | High threshold in [15:12], low threshold in [7:4] |
| bus_wr | input | 1 | Bus write to the data address |
| bus_rd | input | 1 | Bus read of the data address |
| bus_size | input | 2 | Access size code: 0=1 byte, 1=2, 2=4, 3=illegal |
| bus_wdata | input | 32 | Write data, first byte in the top lane |
| bus_rdata | output | 32 | Read data, first byte in the top lane |
| eng_push | input | 1 | Engine appends one received byte |
| eng_wbyte | input | 8 | Byte appended by the engine |
| eng_pop | input | 1 | Engine takes one byte to transmit |
| eng_rbyte | output | 8 | Oldest byte held |
| stat_word | output | 32 | [25] service request, [7:0] fill count |
| ext_word | output | 32 | [31:24] capacity, [9] high-water, [8] low-water |
| fifo_err | output | 1 | Sticky refused-access error |

## Verification
The hardest situation to reach is a multi-byte access that straddles the pointer wrap while the other side removes a byte in the same cycle. At that point the refusal decision and the byte order both depend on the count at the start of the cycle. The bench first sweeps the whole fill range byte by byte under every pairing of complementary thresholds. It then runs a long transmit sequence of 4-, 2- and 1-byte writes interleaved with engine pops, some of them simultaneous. This pushes the write pointer through the wrap many times at different offsets. Every step is compared against a byte-queue model kept in the bench.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int LANES = 4;
  typedef logic [LANES-1:0][7:0] lane_vec_t;

  // size code to byte count; 0 marks the illegal code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // k-th byte of a bus word, counted from the most significant lane
  function automatic logic [7:0] word_lane(input logic [31:0] w, input int unsigned k);
    return w[31-8*k -: 8];
  endfunction

  // place the first n lanes from the top of the word, zero the rest
  function automatic logic [31:0] pack_lanes(input lane_vec_t lanes, input logic [2:0] n);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < LANES; k++)
      if (3'(k) < n) w[31-8*k -: 8] = lanes[k];
    return w;
  endfunction

  function automatic logic hi_reached(input logic [7:0] cnt, input logic [3:0] thr);
    return cnt >= {4'b0, thr};
  endfunction

  function automatic logic lo_reached(input logic [7:0] cnt, input logic [3:0] thr);
    return cnt <= {4'b0, thr};
  endfunction
endpackage

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_mode,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_size,
  input  logic          eng_push,
  input  logic          eng_pop,
  output logic [2:0]    push_n,
  output logic [2:0]    pop_n,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cnt_next,
  output logic          moved,
  output logic          err
);
  logic [2:0]    req_n;
  logic          bus_push_req, bus_pop_req, eng_push_req, eng_pop_req;
  logic [2:0]    want_push, want_pop;
  logic [CW-1:0] free_slots;
  logic          push_ok, pop_ok, bad_size, err_evt;

  assign req_n        = size_bytes(bus_size);
  assign bus_push_req = !rx_mode && bus_wr;
  assign eng_pop_req  = !rx_mode && eng_pop;
  assign bus_pop_req  = rx_mode && bus_rd;
  assign eng_push_req = rx_mode && eng_push;

  assign want_push = bus_push_req ? req_n : (eng_push_req ? 3'd1 : 3'd0);
  assign want_pop  = bus_pop_req  ? req_n : (eng_pop_req  ? 3'd1 : 3'd0);
  assign bad_size  = (bus_push_req || bus_pop_req) && (req_n == 3'd0);

  assign free_slots = CW'(DEPTH) - count;
  assign push_ok    = (want_push != 3'd0) && (CW'(want_push) <= free_slots);
  assign pop_ok     = (want_pop  != 3'd0) && (CW'(want_pop)  <= count);

  assign err_evt = !flush && (bad_size
                   || ((want_push != 3'd0) && !push_ok)
                   || ((want_pop  != 3'd0) && !pop_ok));

  assign push_n   = (push_ok && !flush) ? want_push : 3'd0;
  assign pop_n    = (pop_ok  && !flush) ? want_pop  : 3'd0;
  assign moved    = (push_n != 3'd0) || (pop_n != 3'd0);
  assign cnt_next = count + CW'(push_n) - CW'(pop_n);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      err   <= 1'b0;
    end else begin
      wptr  <= wptr + PW'(push_n);
      rptr  <= rptr + PW'(pop_n);
      count <= cnt_next;
      err   <= err || err_evt;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !flush) |=> err);
  assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !moved) |=> (count == $past(count)) && err);
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !err);
  assert_wrong_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode && !bus_wr && !eng_pop && !flush) |=> (count == $past(count)) && (err == $past(err)));
endmodule

// File: rtl/bfifo_store.sv
module bfifo_store
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [2:0]    wr_n,
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr,
  input  lane_vec_t     wr_lanes,
  output lane_vec_t     rd_lanes
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (3'(k) < wr_n) mem[wptr + PW'(k)] <= wr_lanes[k];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign rd_lanes[g] = mem[rptr + PW'(g)];
  end
endmodule

// File: rtl/bfifo_wmark.sv
module bfifo_wmark
  import bfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       rx_mode,
  input  logic       moved,
  input  logic [7:0] cnt_next,
  input  logic [3:0] hi_thr,
  input  logic [3:0] lo_thr,
  output logic       hi_flag,
  output logic       lo_flag,
  output logic       dreq
);
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hi_flag <= 1'b0;
      lo_flag <= 1'b0;
    end else if (moved) begin
      hi_flag <= hi_reached(cnt_next, hi_thr);
      lo_flag <= lo_reached(cnt_next, lo_thr);
    end
  end

  assign dreq = rx_mode ? hi_flag : lo_flag;

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!moved && !flush) |=> $stable(hi_flag) && $stable(lo_flag));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hi_flag && !lo_flag);
endmodule

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        rx_mode,
  input  logic [15:0] wmark_cfg,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_push,
  input  logic [7:0]  eng_wbyte,
  input  logic        eng_pop,
  output logic [7:0]  eng_rbyte,
  output logic [31:0] stat_word,
  output logic [31:0] ext_word,
  output logic        fifo_err
);
  logic [2:0]    push_n, pop_n;
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count, cnt_next;
  logic          moved, hi_flag, lo_flag, dreq;
  lane_vec_t     wr_lanes, rd_lanes;

  bfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rx_mode(rx_mode),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
    .eng_push(eng_push), .eng_pop(eng_pop),
    .push_n(push_n), .pop_n(pop_n), .wptr(wptr), .rptr(rptr),
    .count(count), .cnt_next(cnt_next), .moved(moved), .err(fifo_err)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (rx_mode) wr_lanes[k] = (k == 0) ? eng_wbyte : 8'h00;
      else         wr_lanes[k] = word_lane(bus_wdata, k);
    end
  end

  bfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_n(push_n), .wptr(wptr), .rptr(rptr),
    .wr_lanes(wr_lanes), .rd_lanes(rd_lanes)
  );

  bfifo_wmark u_wmark (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rx_mode(rx_mode),
    .moved(moved), .cnt_next(8'(cnt_next)),
    .hi_thr(wmark_cfg[15:12]), .lo_thr(wmark_cfg[7:4]),
    .hi_flag(hi_flag), .lo_flag(lo_flag), .dreq(dreq)
  );

  assign bus_rdata = (rx_mode && bus_rd) ? pack_lanes(rd_lanes, pop_n) : 32'h0;
  assign eng_rbyte = rd_lanes[0];
  assign stat_word = {6'b0, dreq, 17'b0, 8'(count)};
  assign ext_word  = {8'(DEPTH), 14'b0, hi_flag, lo_flag, 8'b0};

  assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_mode && bus_rd) |-> (bus_rdata == 32'h0));
  assert_dreq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[25] |-> (ext_word[9] || ext_word[8]));
endmodule

// File: tb/i2c_byte_fifo_bench.sv
`timescale 1ns/1ps
module i2c_byte_fifo_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, rx_mode = 1'b0;
  logic [15:0] wmark_cfg = 16'h0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        eng_push = 1'b0, eng_pop = 1'b0;
  logic [7:0]  eng_wbyte = 8'h0;
  logic [7:0]  eng_rbyte;
  logic [31:0] stat_word, ext_word;
  logic        fifo_err;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit m_err = 0, m_hi = 0, m_lo = 0;
  int wm_hi = 0, wm_lo = 0;

  always #2.5 clk = ~clk;

  i2c_byte_fifo #(.DEPTH(DEPTH)) u_i2c_byte_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rx_mode(rx_mode),
    .wmark_cfg(wmark_cfg), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_push(eng_push), .eng_wbyte(eng_wbyte), .eng_pop(eng_pop),
    .eng_rbyte(eng_rbyte), .stat_word(stat_word), .ext_word(ext_word),
    .fifo_err(fifo_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_status();
    chk("R4 count", {24'b0, stat_word[7:0]}, q.size());
    chk("R7 flags", {30'b0, ext_word[9:8]}, {30'b0, m_hi, m_lo});
    chk("R8 dreq", {31'b0, stat_word[25]}, {31'b0, rx_mode ? m_hi : m_lo});
    chk("R5 err", {31'b0, fifo_err}, {31'b0, m_err});
    chk("R1 capacity", {24'b0, ext_word[31:24]}, DEPTH);
  endtask

  task automatic set_wm(input int h, input int l);
    wm_hi = h; wm_lo = l;
    wmark_cfg = {4'(h), 4'h0, 4'(l), 4'h0};
  endtask

  task automatic xfer(input string tag, input bit bw, input bit br, input bit [1:0] sz,
                      input bit [31:0] wd, input bit ep, input bit [7:0] eb,
                      input bit epop, input bit fl);
    int n, wpush, wpop;
    bit bad, pushok, popok;
    logic [31:0] exp_rd;
    logic [7:0] head;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    wpush = (!rx_mode && bw) ? n : ((rx_mode && ep) ? 1 : 0);
    wpop  = (rx_mode && br) ? n : ((!rx_mode && epop) ? 1 : 0);
    bad   = ((!rx_mode && bw) || (rx_mode && br)) && (n == 0);
    pushok = (wpush != 0) && (q.size() + wpush <= DEPTH);
    popok  = (wpop != 0) && (wpop <= q.size());
    exp_rd = 32'h0;
    if (!fl && rx_mode && br && popok)
      for (int k = 0; k < n; k++) exp_rd[31-8*k -: 8] = q[k];
    head = (q.size() > 0) ? q[0] : 8'h00;
    bus_wr = bw; bus_rd = br; bus_size = sz; bus_wdata = wd;
    eng_push = ep; eng_wbyte = eb; eng_pop = epop; flush = fl;
    #1;
    if (br) chk(tag, bus_rdata, exp_rd);
    if (!rx_mode && epop && popok && !fl) chk(tag, {24'b0, eng_rbyte}, {24'b0, head});
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; bus_size = 0; bus_wdata = 0;
    eng_push = 0; eng_wbyte = 0; eng_pop = 0; flush = 0;
    if (fl) begin
      q.delete(); m_err = 0; m_hi = 0; m_lo = 0;
    end else begin
      if (bad || (wpush != 0 && !pushok) || (wpop != 0 && !popok)) m_err = 1;
      if (popok) for (int k = 0; k < wpop; k++) void'(q.pop_front());
      if (pushok) begin
        if (rx_mode) q.push_back(eb);
        else for (int k = 0; k < n; k++) q.push_back(wd[31-8*k -: 8]);
      end
      if (pushok || popok) begin
        m_hi = (q.size() >= wm_hi);
        m_lo = (q.size() <= wm_lo);
      end
    end
    check_status();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset stat", stat_word, 32'h0);
    chk("R1 reset ext", ext_word, 32'(DEPTH) << 24);
    chk("R1 reset err", {31'b0, fifo_err}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset stat", stat_word, 32'h0);
    chk("R1 after reset ext", ext_word, 32'(DEPTH) << 24);

    // full sweep of fill levels under complementary thresholds (transmit)
    rx_mode = 0;
    for (int h = 0; h < 16; h++) begin
      set_wm(h, 15 - h);
      xfer("R9", 0, 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < DEPTH; i++)
        xfer("R2", 1, 0, 2'd0, {8'(h * 16 + i), 24'hABCDEF}, 0, 0, 0, 0);
      xfer("R5 overfill", 1, 0, 2'd0, 32'h5A000000, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++)
        xfer("R2", 0, 0, 0, 0, 0, 0, 1, 0);
      xfer("R5 underflow", 0, 0, 0, 0, 0, 0, 1, 0);
    end

    // wrong-side accesses in transmit mode
    set_wm(8, 3);
    xfer("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    xfer("R2", 1, 0, 2'd1, 32'h11223344, 0, 0, 0, 0);
    xfer("R6 tx bus read", 0, 1, 2'd2, 0, 0, 0, 0, 0);
    xfer("R6 tx eng push", 0, 0, 0, 0, 1, 8'h77, 0, 0);
    xfer("R2", 0, 0, 0, 0, 0, 0, 1, 0);
    xfer("R2", 0, 0, 0, 0, 0, 0, 1, 0);
    xfer("R5 size code 3", 1, 0, 2'd3, 32'hFFFFFFFF, 0, 0, 0, 0);
    xfer("R9 flush priority", 1, 0, 2'd2, 32'hDEADBEEF, 0, 0, 0, 1);

    // receive mode: engine fills, bus reads of mixed width
    rx_mode = 1;
    set_wm(8, 2);
    for (int i = 0; i < DEPTH; i++)
      xfer("R3", 0, 0, 0, 0, 1, 8'(8'hA0 + i), 0, 0);
    xfer("R5 rx overfill", 0, 0, 0, 0, 1, 8'hEE, 0, 0);
    xfer("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 15; i++)
      xfer("R3", 0, 0, 0, 0, 1, 8'(8'hB0 + i), 0, 0);
    xfer("R3", 0, 1, 2'd2, 0, 0, 0, 0, 0);
    xfer("R3", 0, 1, 2'd1, 0, 0, 0, 0, 0);
    xfer("R6 rx bus write", 1, 0, 2'd2, 32'h01020304, 0, 0, 0, 0);
    xfer("R6 rx eng pop", 0, 0, 0, 0, 0, 0, 1, 0);
    xfer("R3", 0, 1, 2'd0, 0, 0, 0, 0, 0);
    xfer("R3", 0, 1, 2'd2, 0, 0, 0, 0, 0);
    xfer("R3", 0, 1, 2'd2, 0, 0, 0, 0, 0);
    xfer("R5 rx short read", 0, 1, 2'd2, 0, 0, 0, 0, 0);
    xfer("R3", 0, 1, 2'd1, 0, 0, 0, 0, 0);
    xfer("R6 idle read lanes", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 rdata idle", bus_rdata, 32'h0);

    // transmit wrap with mixed widths and simultaneous pops
    rx_mode = 0;
    set_wm(12, 4);
    xfer("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 60; i++) begin
      bit [1:0] sz;
      sz = 2'(i % 3);
      xfer("R11", 1, 0, (sz == 2'd0) ? 2'd2 : (sz == 2'd1) ? 2'd1 : 2'd0,
           {8'(i * 4), 8'(i * 4 + 1), 8'(i * 4 + 2), 8'(i * 4 + 3)}, 0, 0, 0, 0);
      xfer("R10", 1, 0, 2'd0, {8'(8'hC0 + i), 24'h0}, 0, 0, 1, 0);
      xfer("R11", 0, 0, 0, 0, 0, 0, 1, 0);
      xfer("R11", 0, 0, 0, 0, 0, 0, 1, 0);
    end
    while (q.size() > 0) xfer("R11", 0, 0, 0, 0, 0, 0, 1, 0);
    // fill to full, then push and pop together: push refused, pop accepted
    for (int i = 0; i < 4; i++) xfer("R10", 1, 0, 2'd2, 32'h10203040 + i, 0, 0, 0, 0);
    xfer("R10 full simultaneous", 1, 0, 2'd0, 32'h99000000, 0, 0, 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule